// File: doc/BRIEF.md
# Prefetch Channel Control and Status Registers

This block is the software-visible register file of a display prefetch channel. It sits on a simple 32-bit register bus: byte address, write strobe, write data and a read data return. Every read/write register answers at four word offsets inside a 16-byte slot: the slot base overwrites the register, +0x4 ORs the write data in, +0x8 clears the bits that are 1 in the data, and +0xC inverts them. This lets several agents touch single bits without a read-modify-write.

The block keeps the channel control register (run, soft reset, repeat, shadow-load enable, software load select), an interrupt mask in which a 1 disables a source, a raw event status and its masked view, and staging copies of the frame setup (line pitch, width, height, base address). Hardware event inputs and the channel's own run, load and frame-end events set status bits. Writing the run bit starts a frame and, when both shadow-load bits are set, copies the staged setup into the active outputs that the fetch engine uses. A single level interrupt output is raised while any unmasked status bit is pending.

Top module: `dpc_csr_block`

## Requirements
- R1: Control (0x00), mask (0x20), pitch (0x70, bits 15:0), width (0xA0, bits 15:0), height (0xB0, bits 15:0) and base (0xC0, bits 31:0) take a write at slot+0x0 as replace, +0x4 as OR, +0x8 as clear-where-1 and +0xC as invert; a read at any of the four offsets returns the register, with unimplemented bits reading 0.
- R2: Control bits are run=0, soft reset=1, repeat=2, shadow-load enable=3, software load select=4. The run bit reads 1 right after the write that sets it and 0 one cycle later; that next clock edge starts a frame, raising busy_o and status bit 1.
- R3: A mask bit of 1 suppresses its source. Offset 0x40 reads raw status, 0x30 reads raw AND NOT mask, and irq_o is 1 exactly when the 0x30 value is nonzero. The mask resets to 0xFF; writing 0x07 leaves bits 7:3 enabled and bits 2:0 disabled.
- R4: err_evt_i[k] sets status bit k+3 (k = 0..4); status bit 0 is frame done, bit 1 is run, bit 2 is shadow loaded.
- R5: A write at 0x30 clears each status bit written as 1 and keeps those written as 0; writes at 0x34, 0x38, 0x3C and any write to 0x40..0x4C change nothing, and reads at those status alias offsets return 0.
- R6: When an event and a clear hit the same status bit in one cycle, the bit ends set.
- R7: While soft reset is 1, status reads 0, busy_o is 0, events are not recorded and run writes start nothing; after soft reset is written back to 0, events are recorded again.
- R8: A frame start with shadow-load enable and software select both 1 copies pitch, width, height and base into act_pitch_o, act_width_o, act_height_o and act_base_o on the same edge that raises busy_o, and sets status bit 2; otherwise the active outputs keep their values.
- R9: A frame_done_i pulse while busy sets status bit 0; with repeat 1 the channel stays busy and also sets status bit 1, with repeat 0 busy_o falls.
- R10: Reads of unmapped offsets (including offsets that are not a multiple of 4) return 0 and writes to them change no register.
- R11: After reset: control 0, mask 0xFF, status 0, frame setup and active outputs 0, busy_o 0, irq_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| err_evt_i | input | 5 | Error event pulses (status bits 7:3) |
| frame_done_i | input | 1 | Frame-end pulse from the fetch engine |
| irq_o | output | 1 | Level interrupt, any unmasked pending bit |
| busy_o | output | 1 | Channel is running a frame |
| act_pitch_o | output | DIM_W | Active line pitch |
| act_width_o | output | DIM_W | Active width |
| act_height_o | output | DIM_W | Active height |
| act_base_o | output | BASE_W | Active base address |

## Verification
The properties assume that reset is held long enough for every register to reach its reset value, that inputs change only away from the rising edge, and that an error input and a status clear may coincide but the bus carries at most one write per cycle. The bench drives all inputs on the falling edge, keeps frame_done_i low while it exercises random status traffic so only the error bits move, and keeps random alias writes away from the control register so that soft reset and run are entered only by the directed sequences.

// File: rtl/dpc_regs_pkg.sv
package dpc_regs_pkg;

    localparam int DW    = 32;
    localparam int SYS_W = 5;
    localparam int IRQ_W = 8;
    localparam int ERR_W = 5;
    localparam int NCFG  = 4;

    // access kind selected by address bits 3:2
    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_TOG = 2'd3
    } alias_op_e;

    // register slots, byte offset divided by 16
    localparam logic [7:0] GRP_SYS    = 8'h00;
    localparam logic [7:0] GRP_MASK   = 8'h02;
    localparam logic [7:0] GRP_MSTAT  = 8'h03;
    localparam logic [7:0] GRP_RSTAT  = 8'h04;
    localparam logic [7:0] GRP_PITCH  = 8'h07;
    localparam logic [7:0] GRP_WIDTH  = 8'h0A;
    localparam logic [7:0] GRP_HEIGHT = 8'h0B;
    localparam logic [7:0] GRP_BASE   = 8'h0C;

    localparam int CFG_PITCH  = 0;
    localparam int CFG_WIDTH  = 1;
    localparam int CFG_HEIGHT = 2;
    localparam int CFG_BASE   = 3;

    localparam int SYS_RUN   = 0;
    localparam int SYS_SRST  = 1;
    localparam int SYS_RPT   = 2;
    localparam int SYS_SLEN  = 3;
    localparam int SYS_SWSEL = 4;

    // status layout, msb first: errors, shadow loaded, run, frame done
    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic             shadow_loaded;
        logic             run;
        logic             ctrl_done;
    } irq_vec_t;

    function automatic logic [7:0] cfg_group(input int idx);
        case (idx)
            CFG_PITCH:  return GRP_PITCH;
            CFG_WIDTH:  return GRP_WIDTH;
            CFG_HEIGHT: return GRP_HEIGHT;
            default:    return GRP_BASE;
        endcase
    endfunction

    function automatic logic [DW-1:0] alias_next(input logic [DW-1:0] cur,
                                                 input logic [DW-1:0] d,
                                                 input alias_op_e op);
        case (op)
            OP_SET:  return cur | d;
            OP_CLR:  return cur & ~d;
            OP_TOG:  return cur ^ d;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/dpc_alias_reg.sv
module dpc_alias_reg
    import dpc_regs_pkg::*;
#(
    parameter int         W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] q
);

    // a bus write has priority over the hardware clear
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST;
        else if (wr_en)
            q <= W'(alias_next(DW'(q), DW'(wdata), op));
        else
            q <= q & ~hw_clr;
    end

endmodule

// File: rtl/dpc_irq_status.sv
module dpc_irq_status
    import dpc_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_clr,
    input  irq_vec_t         evt,
    input  logic             w1c_en,
    input  logic [IRQ_W-1:0] w1c_data,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);

    logic [IRQ_W-1:0] clr_bits;
    logic [IRQ_W-1:0] set_bits;

    assign clr_bits = w1c_en ? w1c_data : '0;
    assign set_bits = evt;

    // new events are OR-ed after the clear, so an event wins a collision
    always_ff @(posedge clk) begin
        if (rst || hold_clr)
            raw <= '0;
        else
            raw <= (raw & ~clr_bits) | set_bits;
    end

    assign masked = raw & ~mask;
    assign irq    = |masked;

endmodule

// File: rtl/dpc_run_ctrl.sv
module dpc_run_ctrl #(
    parameter int DIM_W  = 16,
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              run_req,
    input  logic              sl_en,
    input  logic              sw_sel,
    input  logic              repeat_en,
    input  logic              frame_done,
    input  logic [DIM_W-1:0]  sh_pitch,
    input  logic [DIM_W-1:0]  sh_width,
    input  logic [DIM_W-1:0]  sh_height,
    input  logic [BASE_W-1:0] sh_base,
    output logic              busy,
    output logic [DIM_W-1:0]  act_pitch,
    output logic [DIM_W-1:0]  act_width,
    output logic [DIM_W-1:0]  act_height,
    output logic [BASE_W-1:0] act_base,
    output logic              evt_run,
    output logic              evt_shadow,
    output logic              evt_done
);

    logic start;

    assign start      = run_req & ~srst;
    assign evt_done   = frame_done & busy;
    assign evt_run    = start | (evt_done & repeat_en);
    assign evt_shadow = start & sl_en & sw_sel;

    always_ff @(posedge clk) begin
        if (rst || srst)
            busy <= 1'b0;
        else if (start)
            busy <= 1'b1;
        else if (evt_done && !repeat_en)
            busy <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_pitch  <= '0;
            act_width  <= '0;
            act_height <= '0;
            act_base   <= '0;
        end else if (evt_shadow) begin
            act_pitch  <= sh_pitch;
            act_width  <= sh_width;
            act_height <= sh_height;
            act_base   <= sh_base;
        end
    end

endmodule

// File: rtl/dpc_csr_block.sv
module dpc_csr_block
    import dpc_regs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DIM_W  = 16,
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [4:0]        err_evt_i,
    input  logic              frame_done_i,
    output logic              irq_o,
    output logic              busy_o,
    output logic [DIM_W-1:0]  act_pitch_o,
    output logic [DIM_W-1:0]  act_width_o,
    output logic [DIM_W-1:0]  act_height_o,
    output logic [BASE_W-1:0] act_base_o
);

    localparam int GW = ADDR_W - 4;

    logic [GW-1:0]    grp;
    alias_op_e        op;
    logic             aligned;
    logic             wr_any;
    logic [SYS_W-1:0] sys_q;
    logic [IRQ_W-1:0] mask_q;
    logic [IRQ_W-1:0] stat_raw;
    logic [IRQ_W-1:0] stat_masked;
    logic [DW-1:0]    cfg_rd [NCFG];
    logic [DIM_W-1:0] sh_pitch, sh_width, sh_height;
    logic [BASE_W-1:0] sh_base;
    logic             ev_run, ev_shadow, ev_done;
    irq_vec_t         evt;

    assign grp     = reg_addr[ADDR_W-1:4];
    assign op      = alias_op_e'(reg_addr[3:2]);
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign wr_any  = reg_we & aligned;

    // channel control, run bit drops one cycle after it is set
    dpc_alias_reg #(.W(SYS_W), .RST('0)) u_sys (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_any && grp == GW'(GRP_SYS)),
        .op     (op),
        .wdata  (reg_wdata[SYS_W-1:0]),
        .hw_clr ({{(SYS_W-1){1'b0}}, sys_q[SYS_RUN]}),
        .q      (sys_q)
    );

    dpc_alias_reg #(.W(IRQ_W), .RST('1)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_any && grp == GW'(GRP_MASK)),
        .op     (op),
        .wdata  (reg_wdata[IRQ_W-1:0]),
        .hw_clr ('0),
        .q      (mask_q)
    );

    for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
        localparam int CW = (gi == CFG_BASE) ? BASE_W : DIM_W;
        logic [CW-1:0] q;
        dpc_alias_reg #(.W(CW), .RST('0)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_any && grp == GW'(cfg_group(gi))),
            .op     (op),
            .wdata  (reg_wdata[CW-1:0]),
            .hw_clr ('0),
            .q      (q)
        );
        assign cfg_rd[gi] = DW'(q);
    end

    assign sh_pitch  = cfg_rd[CFG_PITCH][DIM_W-1:0];
    assign sh_width  = cfg_rd[CFG_WIDTH][DIM_W-1:0];
    assign sh_height = cfg_rd[CFG_HEIGHT][DIM_W-1:0];
    assign sh_base   = cfg_rd[CFG_BASE][BASE_W-1:0];

    dpc_run_ctrl #(.DIM_W(DIM_W), .BASE_W(BASE_W)) u_run (
        .clk        (clk),
        .rst        (rst),
        .srst       (sys_q[SYS_SRST]),
        .run_req    (sys_q[SYS_RUN]),
        .sl_en      (sys_q[SYS_SLEN]),
        .sw_sel     (sys_q[SYS_SWSEL]),
        .repeat_en  (sys_q[SYS_RPT]),
        .frame_done (frame_done_i),
        .sh_pitch   (sh_pitch),
        .sh_width   (sh_width),
        .sh_height  (sh_height),
        .sh_base    (sh_base),
        .busy       (busy_o),
        .act_pitch  (act_pitch_o),
        .act_width  (act_width_o),
        .act_height (act_height_o),
        .act_base   (act_base_o),
        .evt_run    (ev_run),
        .evt_shadow (ev_shadow),
        .evt_done   (ev_done)
    );

    assign evt.err           = err_evt_i;
    assign evt.shadow_loaded = ev_shadow;
    assign evt.run           = ev_run;
    assign evt.ctrl_done     = ev_done;

    dpc_irq_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .hold_clr (sys_q[SYS_SRST]),
        .evt      (evt),
        .w1c_en   (wr_any && grp == GW'(GRP_MSTAT) && op == OP_WR),
        .w1c_data (reg_wdata[IRQ_W-1:0]),
        .mask     (mask_q),
        .raw      (stat_raw),
        .masked   (stat_masked),
        .irq      (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (grp == GW'(GRP_SYS))
                reg_rdata = DW'(sys_q);
            else if (grp == GW'(GRP_MASK))
                reg_rdata = DW'(mask_q);
            else if (grp == GW'(GRP_MSTAT) && op == OP_WR)
                reg_rdata = DW'(stat_masked);
            else if (grp == GW'(GRP_RSTAT) && op == OP_WR)
                reg_rdata = DW'(stat_raw);
            else
                for (int i = 0; i < NCFG; i++)
                    if (grp == GW'(cfg_group(i)))
                        reg_rdata = cfg_rd[i];
        end
    end

endmodule

// File: rtl/dpc_csr_checker.sv
module dpc_csr_checker #(
    parameter int ADDR_W = 12,
    parameter int DIM_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [31:0]       reg_wdata,
    input logic [4:0]        err_evt_i,
    input logic              frame_done_i,
    input logic              irq_o,
    input logic              busy_o,
    input logic [DIM_W-1:0]  act_pitch_o,
    input logic [4:0]        sys_q,
    input logic [7:0]        mask_q,
    input logic [7:0]        stat_raw,
    input logic [DIM_W-1:0]  sh_pitch
);

    logic sys_wr;
    logic w1c_top;

    assign sys_wr  = reg_we && (reg_addr[ADDR_W-1:4] == '0) && (reg_addr[1:0] == 2'b00);
    assign w1c_top = reg_we && (reg_addr[ADDR_W-1:4] == (ADDR_W-4)'(3))
                     && (reg_addr[3:0] == 4'h0) && reg_wdata[7];

    p_run_selfclear_r2: assert property (@(posedge clk) disable iff (rst)
        (sys_q[0] && !sys_wr) |=> !sys_q[0]);

    p_busy_from_run_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(sys_q[0]));

    p_mask_all_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 8'hFF) |-> !irq_o);

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (w1c_top && !err_evt_i[4]) |=> !stat_raw[7]);

    p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (!sys_q[1] && err_evt_i[0]) |=> stat_raw[3]);

    p_srst_clears_r7: assert property (@(posedge clk) disable iff (rst)
        sys_q[1] |=> (stat_raw == 8'h00 && !busy_o));

    p_shadow_copy_r8: assert property (@(posedge clk) disable iff (rst)
        (sys_q[0] && !sys_q[1] && sys_q[3] && sys_q[4])
        |=> (act_pitch_o == $past(sh_pitch) && stat_raw[2]));

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && frame_done_i && !sys_q[2] && !sys_q[0]) |=> !busy_o);

endmodule

bind dpc_csr_block dpc_csr_checker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .err_evt_i    (err_evt_i),
    .frame_done_i (frame_done_i),
    .irq_o        (irq_o),
    .busy_o       (busy_o),
    .act_pitch_o  (act_pitch_o),
    .sys_q        (sys_q),
    .mask_q       (mask_q),
    .stat_raw     (stat_raw),
    .sh_pitch     (sh_pitch)
);

// File: tb/sim_dpc_csr_block.sv
module sim_dpc_csr_block;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  err_evt_i = '0;
    logic        frame_done_i = 1'b0;
    logic        irq_o, busy_o;
    logic [15:0] act_pitch_o, act_width_o, act_height_o;
    logic [31:0] act_base_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpc_csr_block u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_evt_i(err_evt_i),
        .frame_done_i(frame_done_i), .irq_o(irq_o), .busy_o(busy_o),
        .act_pitch_o(act_pitch_o), .act_width_o(act_width_o),
        .act_height_o(act_height_o), .act_base_o(act_base_o)
    );

    function automatic logic [31:0] alias_model(input logic [31:0] cur,
                                                input logic [31:0] d,
                                                input int op);
        case (op)
            1: return cur | d;
            2: return cur & ~d;
            3: return cur ^ d;
            default: return d;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic err_pulse(input logic [4:0] e);
        @(negedge clk);
        err_evt_i = e;
        @(negedge clk);
        err_evt_i = '0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        frame_done_i = 1'b1;
        @(negedge clk);
        frame_done_i = 1'b0;
    endtask

    task automatic evt_and_clear(input logic [4:0] e, input logic [7:0] c);
        @(negedge clk);
        err_evt_i = e; reg_addr = 12'h030; reg_wdata = {24'h0, c}; reg_we = 1'b1;
        @(negedge clk);
        err_evt_i = '0; reg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] m_reg [5];
        logic [31:0] wmask [5];
        logic [11:0] addr_of [5];
        logic [7:0]  m_raw, m_mask;

        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(12'h000, v); chk("R11 control", v, 32'h0);
        rd(12'h020, v); chk("R11 mask", v, 32'hFF);
        rd(12'h040, v); chk("R11 raw status", v, 32'h0);
        rd(12'h0C0, v); chk("R11 base", v, 32'h0);
        chk("R11 busy", {31'h0, busy_o}, 32'h0);
        chk("R11 irq", {31'h0, irq_o}, 32'h0);
        chk("R11 act base", act_base_o, 32'h0);

        // R10 unmapped offsets
        rd(12'h050, v); chk("R10 read 0x50", v, 32'h0);
        rd(12'h022, v); chk("R10 read unaligned", v, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h071, 32'hFFFF_FFFF);
        rd(12'h000, v); chk("R10 control untouched", v, 32'h0);
        rd(12'h070, v); chk("R10 pitch untouched", v, 32'h0);
        rd(12'h010, v); chk("R10 read 0x10", v, 32'h0);

        // R1 random alias traffic on mask and frame setup
        addr_of = '{12'h020, 12'h070, 12'h0A0, 12'h0B0, 12'h0C0};
        wmask   = '{32'hFF, 32'hFFFF, 32'hFFFF, 32'hFFFF, 32'hFFFF_FFFF};
        m_reg   = '{32'hFF, 32'h0, 32'h0, 32'h0, 32'h0};
        for (int i = 0; i < 60; i++) begin
            int idx, op, rop;
            logic [31:0] d;
            idx = $urandom_range(0, 4);
            op  = $urandom_range(0, 3);
            rop = $urandom_range(0, 3);
            d   = $urandom;
            if (i < 4) begin idx = 4; op = i; d = 32'hF0F0_00FF; end
            wr(addr_of[idx] | 12'(op << 2), d);
            m_reg[idx] = alias_model(m_reg[idx], d, op) & wmask[idx];
            rd(addr_of[idx] | 12'(rop << 2), v);
            chk("R1 alias write/read", v, m_reg[idx]);
        end

        // frame setup for the load tests, mask errors-only
        wr(12'h070, 32'h0000_1234);
        wr(12'h0A0, 32'h0000_0280);
        wr(12'h0B0, 32'h0000_01E0);
        wr(12'h0C0, 32'h8000_1000);
        wr(12'h020, 32'h07);
        rd(12'h020, v); chk("R3 mask 0x07", v, 32'h07);

        // R2 run without shadow load
        wr(12'h000, 32'h01);
        rd(12'h000, v); chk("R2 run reads 1", v, 32'h01);
        tick();
        rd(12'h000, v); chk("R2 run self-clears", v, 32'h0);
        chk("R2 busy", {31'h0, busy_o}, 32'h1);
        rd(12'h040, v); chk("R2 run event", v, 32'h02);
        chk("R8 no load without enables", {16'h0, act_pitch_o}, 32'h0);
        chk("R3 control irqs masked", {31'h0, irq_o}, 32'h0);

        // R9 frame end without repeat
        done_pulse();
        rd(12'h040, v); chk("R9 done event", v, 32'h03);
        chk("R9 idle after done", {31'h0, busy_o}, 32'h0);

        // R8 software shadow load
        wr(12'h000, 32'h19);
        tick();
        chk("R8 pitch", {16'h0, act_pitch_o}, 32'h1234);
        chk("R8 width", {16'h0, act_width_o}, 32'h0280);
        chk("R8 height", {16'h0, act_height_o}, 32'h01E0);
        chk("R8 base", act_base_o, 32'h8000_1000);
        rd(12'h040, v); chk("R8 shadow-loaded event", v, 32'h07);
        rd(12'h000, v); chk("R2 run cleared, enables kept", v, 32'h18);

        // R9 repeat mode
        wr(12'h000, 32'h04);
        wr(12'h030, 32'h07);
        rd(12'h040, v); chk("R5 clear control bits", v, 32'h0);
        done_pulse();
        rd(12'h040, v); chk("R9 repeat done+run", v, 32'h03);
        chk("R9 repeat stays busy", {31'h0, busy_o}, 32'h1);
        done_pulse();
        chk("R9 still busy", {31'h0, busy_o}, 32'h1);
        chk("R8 no reload on repeat", {16'h0, act_pitch_o}, 32'h1234);

        // R3/R4 error interrupt and masking via aliases
        chk("R3 irq low", {31'h0, irq_o}, 32'h0);
        err_pulse(5'b00001);
        rd(12'h040, v); chk("R4 axi-read event bit3", v, 32'h0B);
        rd(12'h030, v); chk("R3 masked view", v, 32'h08);
        chk("R3 irq high", {31'h0, irq_o}, 32'h1);
        wr(12'h024, 32'h08);
        rd(12'h020, v); chk("R1 mask set alias", v, 32'h0F);
        rd(12'h030, v); chk("R3 masked after set", v, 32'h0);
        chk("R3 irq suppressed", {31'h0, irq_o}, 32'h0);
        rd(12'h040, v); chk("R3 raw keeps bit", v, 32'h0B);
        wr(12'h028, 32'h08);
        rd(12'h020, v); chk("R1 mask clear alias", v, 32'h07);

        // R6 event beats clear
        evt_and_clear(5'b00010, 8'h18);
        rd(12'h040, v); chk("R6 event wins, other bit cleared", v, 32'h13);

        // R5 write-one-to-clear details
        wr(12'h030, 32'h00);
        rd(12'h040, v); chk("R5 zero keeps", v, 32'h13);
        wr(12'h040, 32'hFF);
        rd(12'h040, v); chk("R5 raw write ignored", v, 32'h13);
        wr(12'h034, 32'hFF);
        rd(12'h040, v); chk("R5 status alias ignored", v, 32'h13);
        rd(12'h034, v); chk("R5 status alias reads 0", v, 32'h0);
        wr(12'h030, 32'h01);
        rd(12'h040, v); chk("R5 one clears", v, 32'h12);

        // R7 soft reset
        wr(12'h000, 32'h02);
        tick();
        rd(12'h040, v); chk("R7 status held clear", v, 32'h0);
        chk("R7 busy cleared", {31'h0, busy_o}, 32'h0);
        err_pulse(5'b00100);
        rd(12'h040, v); chk("R7 events dropped", v, 32'h0);
        wr(12'h004, 32'h01);
        tick();
        chk("R7 run ignored", {31'h0, busy_o}, 32'h0);
        rd(12'h000, v); chk("R7 control after run", v, 32'h02);
        wr(12'h008, 32'h02);
        err_pulse(5'b00010);
        rd(12'h040, v); chk("R7 resumes", v, 32'h10);

        // R4/R5/R6/R3 random error traffic with coincident clears
        wr(12'h030, 32'hFF);
        m_raw = 8'h0;
        for (int i = 0; i < 40; i++) begin
            logic [4:0] e;
            logic [7:0] c;
            m_mask = 8'($urandom);
            wr(12'h020, {24'h0, m_mask});
            e = 5'($urandom);
            c = 8'($urandom);
            evt_and_clear(e, c);
            m_raw = (m_raw & ~c) | {e, 3'b000};
            rd(12'h040, v); chk("R4 random raw", v, {24'h0, m_raw});
            rd(12'h030, v); chk("R3 random masked", v, {24'h0, m_raw & ~m_mask});
            chk("R3 random irq", {31'h0, irq_o}, {31'h0, |(m_raw & ~m_mask)});
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule